// File: doc/BRIEF.md
# Receive Downstream Alarm Substitution Generator

This block decides when a receive framer stops passing the recovered DS3 or E3 payload downstream and sends an unframed all-ones alarm pattern in its place. Software can force the alarm. When automatic insertion is enabled, the alarm is also raised by the status flags from the rest of the framer: an incoming alarm pattern, loss of signal, or out-of-frame. In the two DS3 framing modes, an out-of-frame condition raises the alarm only after it has lasted for a programmable number of reference strobes. Firmware sets that number so that it corresponds to 2.5 ms. In the E3 and clear-channel modes, out-of-frame acts at once.

The substituted stream goes to the receive payload output. While payload loopback is enabled, the same substituted stream also goes back toward the transmit side in place of the normal transmit data. The alarm flag is registered. The data paths are combinational from that flag and from the incoming data.

Top module: `ais_downstream_gen`

## Requirements
- R1: When `cfg_force` is 1 at a clock edge, `ais_active` is 1 after that edge, whatever the values of `cfg_auto` and the status flags.
- R2: When `cfg_auto` is 1 and either `st_ais` or `st_los` is 1 at a clock edge, `ais_active` is 1 after that edge, in every framing mode.
- R3: In the DS3 modes (`cfg_mode` 0 or 1), an internal count runs while `st_oof` stays 1. The count rises by one on each edge at which `ref_tick` is 1, and it stops at `cfg_persist_limit`. Out-of-frame raises the alarm on the edge after the edge at which the count reaches the limit.
- R4: In the E3 mode (`cfg_mode` 2) and the clear-channel mode (`cfg_mode` 3), `cfg_auto` = 1 together with `st_oof` = 1 at an edge sets `ais_active` after that edge. There is no persistence delay.
- R5: When `cfg_auto` is 0, the values of `st_ais`, `st_los` and `st_oof` have no effect on `ais_active`.
- R6: While `ais_active` is 1, every bit of `rx_out` is 1. Otherwise `rx_out` equals `rx_in`.
- R7: While `plb_en` is 1, `tx_loop_out` equals `rx_out`, including the substituted all-ones stream. While `plb_en` is 0, `tx_loop_out` equals `tx_in`.
- R8: When `cfg_force` is 0 and no enabled trigger is present at an edge, `ais_active` is 0 after that edge.
- R9: Reset clears `ais_active` and the persistence count. After reset, a DS3 out-of-frame condition therefore needs the full count before it raises the alarm.
- R10: If `cfg_persist_limit` is 0, DS3 out-of-frame raises the alarm on the next edge, as in R4.
- R11: When `st_oof` falls to 0, the count returns to 0. A new out-of-frame episode then needs the full count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_force | input | 1 | Software force of the alarm pattern |
| cfg_auto | input | 1 | Enables the automatic triggers |
| cfg_mode | input | 2 | Framing mode: 0 DS3 C-bit, 1 DS3 M23, 2 E3, 3 clear channel |
| cfg_persist_limit | input | CNT_W | Number of reference strobes that out-of-frame must last in the DS3 modes |
| ref_tick | input | 1 | Reference strobe that advances the persistence count |
| st_ais | input | 1 | Incoming alarm pattern detected |
| st_los | input | 1 | Loss of signal |
| st_oof | input | 1 | Out-of-frame |
| plb_en | input | 1 | Payload loopback enable |
| rx_in | input | DATA_W | Recovered receive payload |
| tx_in | input | DATA_W | Normal transmit payload |
| ais_active | output | 1 | Alarm substitution in effect |
| rx_out | output | DATA_W | Receive payload after substitution |
| tx_loop_out | output | DATA_W | Transmit payload after the loopback selection |

## Verification
Two events can fall in the same clock: the persistence count can reach its limit on the very edge at which out-of-frame drops or a competing trigger appears. Also, a loopback change can coincide with the alarm turning on or off. Random stimulus holds out-of-frame for runs of varying length against a small limit, while the strobe, the other flags, the force bit and the loopback enable toggle independently. Directed cases also align the limit-reaching strobe with these edges. Every cycle, the alarm flag and both data outputs are compared with a bench model that applies the requirement rules to the same inputs. The comparison shows whether the alarm rose on exactly the right edge and whether the loopback carried the substituted stream.

// File: rtl/ais_gen_pkg.sv
package ais_gen_pkg;

   typedef enum logic [1:0] {
      FRM_DS3_CBIT = 2'd0,
      FRM_DS3_M23  = 2'd1,
      FRM_E3       = 2'd2,
      FRM_CLEAR    = 2'd3
   } frm_mode_e;

   function automatic logic mode_is_ds3(input logic [1:0] m);
      return (m == FRM_DS3_CBIT) || (m == FRM_DS3_M23);
   endfunction

endpackage

// File: rtl/ais_persist_timer.sv
module ais_persist_timer #(
   parameter int CNT_W     = 16,
   parameter bit PERSIST_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             oof,
   input  logic             tick,
   input  logic [CNT_W-1:0] limit,
   output logic             reached
);

   generate
      if (PERSIST_EN) begin : g_timer
         logic [CNT_W-1:0] cnt_q;
         logic             below_lim;

         assign below_lim = (cnt_q < limit);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!oof) begin
               cnt_q <= '0;
            end else if (tick && below_lim) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign reached = oof && !below_lim;
      end else begin : g_bypass
         assign reached = oof;
      end
   endgenerate

endmodule

// File: rtl/ais_trigger.sv
module ais_trigger (
   input  logic clk,
   input  logic rst_n,
   input  logic force_on,
   input  logic auto_on,
   input  logic ds3_mode,
   input  logic ais_flag,
   input  logic los_flag,
   input  logic oof_flag,
   input  logic oof_persist,
   output logic active
);

   logic oof_cause;
   logic auto_cause;
   logic next_active;

   always_comb begin
      oof_cause   = ds3_mode ? oof_persist : oof_flag;
      auto_cause  = auto_on && (ais_flag || los_flag || oof_cause);
      next_active = force_on || auto_cause;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) active <= 1'b0;
      else        active <= next_active;
   end

endmodule

// File: rtl/ais_stream_route.sv
module ais_stream_route #(
   parameter int DATA_W = 1
) (
   input  logic              sub_on,
   input  logic              loop_on,
   input  logic [DATA_W-1:0] rx_d,
   input  logic [DATA_W-1:0] tx_d,
   output logic [DATA_W-1:0] rx_q,
   output logic [DATA_W-1:0] tx_q
);

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_lane
         assign rx_q[gi] = sub_on | rx_d[gi];
         assign tx_q[gi] = loop_on ? rx_q[gi] : tx_d[gi];
      end
   endgenerate

endmodule

// File: rtl/ais_downstream_gen.sv
module ais_downstream_gen #(
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 1,
   parameter bit PERSIST_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_force,
   input  logic              cfg_auto,
   input  logic [1:0]        cfg_mode,
   input  logic [CNT_W-1:0]  cfg_persist_limit,
   input  logic              ref_tick,
   input  logic              st_ais,
   input  logic              st_los,
   input  logic              st_oof,
   input  logic              plb_en,
   input  logic [DATA_W-1:0] rx_in,
   input  logic [DATA_W-1:0] tx_in,
   output logic              ais_active,
   output logic [DATA_W-1:0] rx_out,
   output logic [DATA_W-1:0] tx_loop_out
);
   import ais_gen_pkg::*;

   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("ais_downstream_gen: CNT_W must lie in 1..32");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("ais_downstream_gen: DATA_W must lie in 1..64");
      end
   endgenerate

   logic ds3_sel;
   logic oof_held;

   assign ds3_sel = mode_is_ds3(cfg_mode);

   ais_persist_timer #(
      .CNT_W      (CNT_W),
      .PERSIST_EN (PERSIST_EN)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .oof     (st_oof),
      .tick    (ref_tick),
      .limit   (cfg_persist_limit),
      .reached (oof_held)
   );

   ais_trigger u_trig (
      .clk         (clk),
      .rst_n       (rst_n),
      .force_on    (cfg_force),
      .auto_on     (cfg_auto),
      .ds3_mode    (ds3_sel),
      .ais_flag    (st_ais),
      .los_flag    (st_los),
      .oof_flag    (st_oof),
      .oof_persist (oof_held),
      .active      (ais_active)
   );

   ais_stream_route #(
      .DATA_W (DATA_W)
   ) u_route (
      .sub_on  (ais_active),
      .loop_on (plb_en),
      .rx_d    (rx_in),
      .tx_d    (tx_in),
      .rx_q    (rx_out),
      .tx_q    (tx_loop_out)
   );

endmodule

// File: rtl/ais_downstream_gen_chk.sv
module ais_downstream_gen_chk #(
   parameter int CNT_W      = 16,
   parameter int DATA_W     = 1,
   parameter bit PERSIST_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_force,
   input logic              cfg_auto,
   input logic [1:0]        cfg_mode,
   input logic [CNT_W-1:0]  cfg_persist_limit,
   input logic              st_ais,
   input logic              st_los,
   input logic              st_oof,
   input logic              plb_en,
   input logic [DATA_W-1:0] rx_in,
   input logic [DATA_W-1:0] tx_in,
   input logic              ais_active,
   input logic [DATA_W-1:0] rx_out,
   input logic [DATA_W-1:0] tx_loop_out
);

   assert_force_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_force |=> ais_active);

   assert_auto_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto && (st_ais || st_los)) |=> ais_active);

   assert_oof_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (PERSIST_EN && $rose(st_oof) && !cfg_mode[1] && cfg_auto && !cfg_force &&
       !st_ais && !st_los && (cfg_persist_limit != '0)) |=> !ais_active);

   assert_oof_direct_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_auto && st_oof && cfg_mode[1]) |=> ais_active);

   assert_manual_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_auto && !cfg_force) |=> !ais_active);

   assert_all_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ais_active |-> (rx_out == {DATA_W{1'b1}}));

   assert_pass_rx_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ais_active |-> (rx_out == rx_in));

   assert_loop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      plb_en |-> (tx_loop_out == rx_out));

   assert_noloop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !plb_en |-> (tx_loop_out == tx_in));

   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_force && !(cfg_auto && (st_ais || st_los || st_oof))) |=> !ais_active);

endmodule

bind ais_downstream_gen ais_downstream_gen_chk #(
   .CNT_W      (CNT_W),
   .DATA_W     (DATA_W),
   .PERSIST_EN (PERSIST_EN)
) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .cfg_force         (cfg_force),
   .cfg_auto          (cfg_auto),
   .cfg_mode          (cfg_mode),
   .cfg_persist_limit (cfg_persist_limit),
   .st_ais            (st_ais),
   .st_los            (st_los),
   .st_oof            (st_oof),
   .plb_en            (plb_en),
   .rx_in             (rx_in),
   .tx_in             (tx_in),
   .ais_active        (ais_active),
   .rx_out            (rx_out),
   .tx_loop_out       (tx_loop_out)
);

// File: tb/ais_downstream_gen_tb_top.sv
module ais_downstream_gen_tb_top;

   localparam int CNT_W  = 16;
   localparam int DATA_W = 4;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              cfg_force, cfg_auto, ref_tick;
   logic [1:0]        cfg_mode;
   logic [CNT_W-1:0]  cfg_persist_limit;
   logic              st_ais, st_los, st_oof, plb_en;
   logic [DATA_W-1:0] rx_in, tx_in;
   logic              ais_active;
   logic [DATA_W-1:0] rx_out, tx_loop_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #10 clk = ~clk;

   ais_downstream_gen #(.CNT_W(CNT_W), .DATA_W(DATA_W), .PERSIST_EN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_force(cfg_force), .cfg_auto(cfg_auto),
      .cfg_mode(cfg_mode), .cfg_persist_limit(cfg_persist_limit), .ref_tick(ref_tick),
      .st_ais(st_ais), .st_los(st_los), .st_oof(st_oof), .plb_en(plb_en),
      .rx_in(rx_in), .tx_in(tx_in), .ais_active(ais_active), .rx_out(rx_out),
      .tx_loop_out(tx_loop_out)
   );

   // Reference model built from the requirement rules
   logic             m_ais;
   logic [CNT_W-1:0] m_cnt;

   function automatic logic model_next(input logic [CNT_W-1:0] c);
      logic ds3, oofc;
      ds3  = (cfg_mode == 2'd0) || (cfg_mode == 2'd1);
      oofc = ds3 ? (st_oof && (c >= cfg_persist_limit)) : st_oof;
      return cfg_force || (cfg_auto && (st_ais || st_los || oofc));
   endfunction

   function automatic logic [DATA_W-1:0] exp_rx();
      return m_ais ? {DATA_W{1'b1}} : rx_in;
   endfunction

   function automatic logic [DATA_W-1:0] exp_tx();
      return plb_en ? exp_rx() : tx_in;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ais <= 1'b0;
         m_cnt <= '0;
      end else begin
         m_ais <= model_next(m_cnt);
         if (!st_oof)                                  m_cnt <= '0;
         else if (ref_tick && m_cnt < cfg_persist_limit) m_cnt <= m_cnt + 1'b1;
      end
   end

   task automatic check(input bit ok, input string req, input logic [63:0] got,
                        input logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic compare_all(input string tag);
      check(ais_active == m_ais, tag, 64'(ais_active), 64'(m_ais));
      check(rx_out == exp_rx(), "R6", 64'(rx_out), 64'(exp_rx()));
      check(tx_loop_out == exp_tx(), "R7", 64'(tx_loop_out), 64'(exp_tx()));
   endtask

   task automatic idle_inputs();
      cfg_force = 0; cfg_auto = 0; cfg_mode = 2'd0; ref_tick = 0;
      st_ais = 0; st_los = 0; st_oof = 0; plb_en = 0;
      rx_in = 4'h5; tx_in = 4'hA; cfg_persist_limit = 16'd4;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0A15));
      idle_inputs();
      rst_n = 1'b0;
      cfg_force = 1'b1; cfg_auto = 1'b1; st_los = 1'b1;
      step(); step();
      // R9: reset dominates every trigger
      check(ais_active == 1'b0, "R9 reset", 64'(ais_active), 64'd0);
      check(rx_out == rx_in, "R9 rx passthrough", 64'(rx_out), 64'(rx_in));
      idle_inputs();
      rst_n = 1'b1;
      step();

      // R1 force without auto
      cfg_force = 1; step();
      check(ais_active == 1'b1, "R1", 64'(ais_active), 64'd1);
      check(rx_out == 4'hF, "R6", 64'(rx_out), 64'hF);
      // R8 release on next clock
      cfg_force = 0; step();
      check(ais_active == 1'b0, "R8", 64'(ais_active), 64'd0);

      // R5 flags ignored with auto off
      st_ais = 1; st_los = 1; st_oof = 1; cfg_mode = 2'd2; step(); step();
      check(ais_active == 1'b0, "R5", 64'(ais_active), 64'd0);
      st_oof = 0; st_ais = 0; st_los = 0; step();

      // R2 LOS in DS3 mode
      cfg_auto = 1; cfg_mode = 2'd1; st_los = 1; step();
      check(ais_active == 1'b1, "R2", 64'(ais_active), 64'd1);
      st_los = 0; step();
      check(ais_active == 1'b0, "R8", 64'(ais_active), 64'd0);

      // R4 OOF immediate in E3 and clear channel
      cfg_mode = 2'd2; st_oof = 1; step();
      check(ais_active == 1'b1, "R4 E3", 64'(ais_active), 64'd1);
      cfg_mode = 2'd3; step();
      check(ais_active == 1'b1, "R4 clear", 64'(ais_active), 64'd1);
      st_oof = 0; step();

      // R3 DS3 persistence: limit 4 with a strobe every cycle, rises on the fifth edge
      cfg_mode = 2'd0; cfg_persist_limit = 16'd4; ref_tick = 1; st_oof = 1;
      for (int i = 1; i <= 5; i++) begin
         step();
         check(ais_active == (i == 5), "R3", 64'(ais_active), 64'(i == 5));
      end

      // R11 dropping OOF clears the count
      st_oof = 0; step();
      check(ais_active == 1'b0, "R11 drop", 64'(ais_active), 64'd0);
      st_oof = 1;
      for (int i = 1; i <= 5; i++) begin
         step();
         check(ais_active == (i == 5), "R11 restart", 64'(ais_active), 64'(i == 5));
      end
      st_oof = 0; step();

      // R10 zero limit is immediate in DS3
      cfg_persist_limit = 16'd0; st_oof = 1; step();
      check(ais_active == 1'b1, "R10", 64'(ais_active), 64'd1);
      st_oof = 0; cfg_persist_limit = 16'd4; step();

      // R7 loopback carries substituted stream
      plb_en = 1; cfg_force = 1; step();
      check(tx_loop_out == 4'hF, "R7 loop ais", 64'(tx_loop_out), 64'hF);
      cfg_force = 0; rx_in = 4'h3; step();
      check(tx_loop_out == 4'h3, "R7 loop data", 64'(tx_loop_out), 64'h3);
      plb_en = 0; #1;
      check(tx_loop_out == tx_in, "R7 no loop", 64'(tx_loop_out), 64'(tx_in));

      // Random mix, OOF held in runs
      cfg_persist_limit = 16'd6;
      begin
         int run = 0;
         for (int c = 0; c < 4000; c++) begin
            if (run == 0) begin
               st_oof = ($urandom_range(0, 2) != 0);
               run    = $urandom_range(1, 14);
            end
            run--;
            ref_tick  = $urandom_range(0, 1);
            cfg_force = ($urandom_range(0, 15) == 0);
            cfg_auto  = ($urandom_range(0, 5) != 0);
            st_ais    = ($urandom_range(0, 19) == 0);
            st_los    = ($urandom_range(0, 19) == 0);
            plb_en    = $urandom_range(0, 1);
            rx_in     = 4'($urandom);
            tx_in     = 4'($urandom);
            if ((c % 500) == 0) cfg_mode = 2'($urandom_range(0, 3));
            step();
            compare_all("R3 R4 R8 random");
         end
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule